// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-side state machine of a small processor whose address and data share one set of lines. The core hands it one transfer at a time: read or write, memory or I/O space, an address and, for writes, a data byte. The sequencer runs that transfer as a machine cycle of four phases, T1 to T4. In T1 it puts the address out and pulses an address latch strobe so that devices can capture it. From T2 it uses the shared lines for data and drives a read or write strobe. The strobe is released in T4.

A slow device can stretch the cycle. It does so by holding the ready input low when the sequencer samples it at the end of T2. Wait phases (Tw) are then inserted between T3 and T4, and every bus output stays exactly as it was in T3. Ready is sampled again at the end of each wait phase. Read data is captured on the clock edge that enters T4 and is handed back to the core during T4.

With no request pending, the sequencer runs idle phases (Ti). During idle it keeps the status of the last cycle on the upper lines. If that cycle was a write, the write byte stays on the shared lines. If it was a read, the shared lines are floated.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the sequencer is idle. The latch strobe is low, both active-low strobes are high, neither line group is driven, and `req_ready` is high.
- R2: A request accepted on a rising edge (with `req_valid` and `req_ready` both high) makes the next cycle T1. In T1 the latch strobe is high for exactly that one cycle, `ad_out` carries address bits [AD_W-1:0], `ah_out` carries the remaining upper address bits, and both groups are driven.
- R3: With ready high, the active strobe is low for exactly two cycles (T2, T3) and goes high in T4. A read uses only `rd_n` and a write only `wr_n`. The two strobes are never low together.
- R4: Ready is sampled only on the edges that end T2 and each Tw. The number of Tw phases equals the number of consecutive low samples taken from the end of T2 onward. Ready low in T1, T3 or T4 has no effect on cycle length.
- R5: During every Tw, `ad_out`, `ad_oe`, `ah_out`, `rd_n` and `wr_n` keep the values they had in T3.
- R6: On a read, the value on `ad_in` at the edge entering T4 appears on `rsp_rdata`, with `rsp_valid` high for the single T4 cycle. A write never raises `rsp_valid`.
- R7: From T2 through T4 a write drives its data byte on `ad_out` with `ad_oe` high. A read keeps `ad_oe` low over the same phases.
- R8: From T2 onward, and through the following idle phases, `ah_out` carries the status word of the cycle: bit 0 is 1 for a write, bit 1 is 1 for I/O space, and all higher bits are 0. `io_sel` is high for I/O space.
- R9: In idle after a write, `ad_oe` stays high with that write byte on `ad_out`. In idle after a read, `ad_oe` is low. In both cases `ah_oe` stays high with the last status word.
- R10: `req_ready` is high only in T4 and Ti. A request pending during T4 starts T1 on the very next cycle, with no idle phase between the two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core has a transfer pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | AD_W | Write byte |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| rsp_valid | output | 1 | Read data valid (T4 of a read) |
| rsp_rdata | output | AD_W | Captured read byte |
| ready_in | input | 1 | Device ready, low requests wait phases |
| ad_in | input | AD_W | Data sensed on the shared lines |
| ad_out | output | AD_W | Value driven on the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ah_out | output | ADDR_W-AD_W | Upper lines: address in T1, status afterwards |
| ah_oe | output | 1 | Drive enable for the upper lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | Cycle targets I/O space |

## Verification
The properties assume that `ready_in` and `ad_in` are settled before every rising edge. They also assume that the request fields do not change between a raised `req_valid` and its acceptance. The bench's device model changes `ready_in` and `ad_in` only on falling edges, and the driver changes the request fields only on falling edges. The device model also derives its ready waveform from a per-transfer wait count, so the number of low samples is known in advance. One transfer deliberately pulls ready low in T3 alone, to show that this phase is not sampled.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    ST_TI = 3'd0,
    ST_T1 = 3'd1,
    ST_T2 = 3'd2,
    ST_T3 = 3'd3,
    ST_TW = 3'd4,
    ST_T4 = 3'd5
  } bus_state_e;

  typedef struct packed {
    logic io;
    logic wr;
  } cyc_kind_t;

  localparam int STAT_W = 2;

  // Next phase of the bus machine
  function automatic bus_state_e step_state(bus_state_e cur, logic take,
                                            logic wait_pend, logic rdy);
    bus_state_e nx;
    case (cur)
      ST_TI:   nx = take ? ST_T1 : ST_TI;
      ST_T1:   nx = ST_T2;
      ST_T2:   nx = ST_T3;
      ST_T3:   nx = wait_pend ? ST_TW : ST_T4;
      ST_TW:   nx = rdy ? ST_T4 : ST_TW;
      ST_T4:   nx = take ? ST_T1 : ST_TI;
      default: nx = ST_TI;
    endcase
    return nx;
  endfunction

  function automatic logic can_accept(bus_state_e s);
    return (s == ST_TI) || (s == ST_T4);
  endfunction

  // Phases in which the command strobe is active
  function automatic logic strobe_phase(bus_state_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

  // Status word: bit0 = write, bit1 = io
  function automatic logic [STAT_W-1:0] status_bits(cyc_kind_t k);
    return {k.io, k.wr};
  endfunction

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       wait_pend,
  input  logic       ready_in,
  output bus_state_e state,
  output logic       accept,
  output logic       enter_t4
);

  bus_state_e nxt;

  always_comb nxt = step_state(state, req_valid, wait_pend, ready_in);

  assign accept   = req_valid && can_accept(state);
  assign enter_t4 = (nxt == ST_T4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_TI;
    else        state <= nxt;
  end

endmodule

// File: rtl/mbs_wait_ctl.sv
module mbs_wait_ctl
  import mbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_state_e state,
  input  logic       ready_in,
  output logic       wait_pend
);

  // Ready is captured on the edge that closes T2; it decides T3 -> Tw
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wait_pend <= 1'b0;
    else if (state == ST_T2)   wait_pend <= !ready_in;
    else if (state == ST_T4)   wait_pend <= 1'b0;
  end

endmodule

// File: rtl/mbs_cyc_reg.sv
module mbs_cyc_reg
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [AD_W-1:0]   req_wdata,
  input  logic              enter_t4,
  input  logic [AD_W-1:0]   ad_in,
  output cyc_kind_t         cyc_kind,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [AD_W-1:0]   cyc_wdata,
  output logic              have_prev,
  output logic [AD_W-1:0]   rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_kind  <= '0;
      cyc_addr  <= '0;
      cyc_wdata <= '0;
      have_prev <= 1'b0;
    end else if (accept) begin
      cyc_kind  <= '{io: req_io, wr: req_write};
      cyc_addr  <= req_addr;
      cyc_wdata <= req_wdata;
      have_prev <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rdata <= '0;
    else if (enter_t4 && !cyc_kind.wr) rdata <= ad_in;
  end

endmodule

// File: rtl/mbs_bus_drv.sv
module mbs_bus_drv
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 8
) (
  input  bus_state_e              state,
  input  cyc_kind_t               cyc_kind,
  input  logic [ADDR_W-1:0]       cyc_addr,
  input  logic [AD_W-1:0]         cyc_wdata,
  input  logic                    have_prev,
  input  logic [AD_W-1:0]         rdata,
  output logic                    ale,
  output logic                    rd_n,
  output logic                    wr_n,
  output logic                    io_sel,
  output logic [AD_W-1:0]         ad_out,
  output logic                    ad_oe,
  output logic [ADDR_W-AD_W-1:0]  ah_out,
  output logic                    ah_oe,
  output logic                    rsp_valid,
  output logic [AD_W-1:0]         rsp_rdata
);

  localparam int UP_W = ADDR_W - AD_W;

  logic [UP_W-1:0] stat_word;
  logic [AD_W-1:0] data_word;

  assign stat_word = {{(UP_W-STAT_W){1'b0}}, status_bits(cyc_kind)};
  assign data_word = cyc_kind.wr ? cyc_wdata : '0;

  always_comb begin
    ale    = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    ad_out = data_word;
    ad_oe  = cyc_kind.wr;
    ah_out = stat_word;
    ah_oe  = 1'b1;
    case (state)
      ST_TI: begin
        ad_oe = have_prev && cyc_kind.wr;
        ah_oe = have_prev;
      end
      ST_T1: begin
        ale    = 1'b1;
        ad_out = cyc_addr[AD_W-1:0];
        ad_oe  = 1'b1;
        ah_out = cyc_addr[ADDR_W-1:AD_W];
      end
      default: begin
        if (strobe_phase(state)) begin
          rd_n = cyc_kind.wr;
          wr_n = !cyc_kind.wr;
        end
      end
    endcase
  end

  assign io_sel    = cyc_kind.io;
  assign rsp_valid = (state == ST_T4) && !cyc_kind.wr;
  assign rsp_rdata = rdata;

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_io,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [AD_W-1:0]        req_wdata,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [AD_W-1:0]        rsp_rdata,
  input  logic                   ready_in,
  input  logic [AD_W-1:0]        ad_in,
  output logic [AD_W-1:0]        ad_out,
  output logic                   ad_oe,
  output logic [ADDR_W-AD_W-1:0] ah_out,
  output logic                   ah_oe,
  output logic                   ale,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic                   io_sel
);

  // Named internal events, used by the bound checker
  bus_state_e        state;
  logic              accept;
  logic              enter_t4;
  logic              wait_pend;
  cyc_kind_t         cyc_kind;
  logic [ADDR_W-1:0] cyc_addr;
  logic [AD_W-1:0]   cyc_wdata;
  logic              have_prev;
  logic [AD_W-1:0]   rdata;
  logic              cyc_wr;

  assign req_ready = can_accept(state);
  assign cyc_wr    = cyc_kind.wr;

  mbs_fsm u_fsm (
    .clk, .rst_n, .req_valid, .wait_pend, .ready_in,
    .state, .accept, .enter_t4
  );

  mbs_wait_ctl u_wait (
    .clk, .rst_n, .state, .ready_in, .wait_pend
  );

  mbs_cyc_reg #(.ADDR_W(ADDR_W), .AD_W(AD_W)) u_cyc (
    .clk, .rst_n, .accept, .req_write, .req_io, .req_addr, .req_wdata,
    .enter_t4, .ad_in, .cyc_kind, .cyc_addr, .cyc_wdata, .have_prev, .rdata
  );

  mbs_bus_drv #(.ADDR_W(ADDR_W), .AD_W(AD_W)) u_drv (
    .state, .cyc_kind, .cyc_addr, .cyc_wdata, .have_prev, .rdata,
    .ale, .rd_n, .wr_n, .io_sel, .ad_out, .ad_oe, .ah_out, .ah_oe,
    .rsp_valid, .rsp_rdata
  );

endmodule

// File: rtl/mbs_sva.sv
module mbs_sva
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ale,
  input logic                   rd_n,
  input logic                   wr_n,
  input logic [AD_W-1:0]        ad_out,
  input logic                   ad_oe,
  input logic [ADDR_W-AD_W-1:0] ah_out,
  input logic                   ah_oe,
  input logic                   ready_in,
  input logic [AD_W-1:0]        ad_in,
  input logic                   rsp_valid,
  input logic [AD_W-1:0]        rsp_rdata,
  input bus_state_e             state,
  input logic                   accept,
  input logic                   enter_t4,
  input logic                   cyc_wr
);

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_accept_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ale);

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_no_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T2 && ready_in) |=> ##1 (state == ST_T4));

  p_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T2 && !ready_in) |=> ##1 (state == ST_TW));

  p_tw_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TW && ready_in) |=> (state == ST_T4));

  p_tw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TW) |-> ($stable(ad_out) && $stable(ad_oe) && $stable(ah_out)
                          && $stable(rd_n) && $stable(wr_n)));

  p_rd_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_t4 && !cyc_wr) |=> (rsp_valid && rsp_rdata == $past(ad_in)));

  p_wr_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  p_rd_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  p_idle_read_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TI && ah_oe && !ah_out[0]) |-> !ad_oe);

  p_idle_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TI && $past(state) != ST_TI) |-> ah_oe);

endmodule

bind mux_bus_seq mbs_sva #(.ADDR_W(ADDR_W), .AD_W(AD_W)) u_sva (
  .clk, .rst_n, .ale, .rd_n, .wr_n, .ad_out, .ad_oe, .ah_out, .ah_oe,
  .ready_in, .ad_in, .rsp_valid, .rsp_rdata, .state, .accept, .enter_t4,
  .cyc_wr
);

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int AD_W   = 8;
  localparam int UP_W   = ADDR_W - AD_W;

  typedef struct {
    logic              wr;
    logic              io;
    logic [ADDR_W-1:0] addr;
    logic [AD_W-1:0]   data;
    int                waits;
    logic              t3_glitch;
  } xfer_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [AD_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [AD_W-1:0] rsp_rdata;
  logic ready_in = 1'b1;
  logic [AD_W-1:0] ad_in = '0;
  logic [AD_W-1:0] ad_out;
  logic ad_oe, ah_oe, ale, rd_n, wr_n, io_sel;
  logic [UP_W-1:0] ah_out;

  int n_cmp = 0, n_bad = 0, cyc = 0, done_cnt = 0, t4_cyc = 0, last_gap = 0;
  bit finished = 0;
  xfer_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq #(.ADDR_W(ADDR_W), .AD_W(AD_W)) uut (
    .clk, .rst_n, .req_valid, .req_write, .req_io, .req_addr, .req_wdata,
    .req_ready, .rsp_valid, .rsp_rdata, .ready_in, .ad_in, .ad_out, .ad_oe,
    .ah_out, .ah_oe, .ale, .rd_n, .wr_n, .io_sel
  );

  function automatic logic [AD_W-1:0] mem_val(logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [UP_W-1:0] stat_of(logic io, logic wr);
    return UP_W'({io, wr});
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  // Driver: push expectation, present request until accepted
  task automatic issue(input logic wr, input logic io, input logic [ADDR_W-1:0] a,
                       input logic [AD_W-1:0] d, input int w, input logic g);
    xfer_t it;
    it.wr = wr; it.io = io; it.addr = a; it.data = d; it.waits = w; it.t3_glitch = g;
    q.push_back(it);
    @(negedge clk);
    req_write = wr; req_io = io; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic release_req();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle_check(input logic drive, input logic [AD_W-1:0] d,
                            input logic [UP_W-1:0] st);
    for (int i = 0; i < 3; i++) begin
      chk("R9 idle ad_oe", ad_oe, drive);
      if (drive) chk("R9 idle write byte", ad_out, d);
      chk("R9 idle ah_oe", ah_oe, 1'b1);
      chk("R8 idle status", ah_out, st);
      chk("R10 idle req_ready", req_ready, 1'b1);
      @(negedge clk);
    end
  endtask

  // Monitor plus device model
  initial begin
    xfer_t it;
    int n, lo_len, exp_n;
    logic [AD_W-1:0] s_ad; logic s_oe, s_rd, s_wr; logic [UP_W-1:0] s_ah;
    forever begin
      @(negedge clk);
      if (rst_n && ale) begin
        last_gap = cyc - t4_cyc;
        if (q.size() == 0) begin
          n_bad++; $display("FAIL R2: got unexpected cycle expected none");
          continue;
        end
        it = q.pop_front();
        chk("R2 address low", ad_out, it.addr[AD_W-1:0]);
        chk("R2 address high", ah_out, it.addr[ADDR_W-1:AD_W]);
        chk("R2 drives", {ad_oe, ah_oe}, 2'b11);
        chk("R10 busy in T1", req_ready, 1'b0);
        ad_in = mem_val(it.addr);
        lo_len = (it.waits == 0) ? 0 : it.waits + 1;
        exp_n = 2 + it.waits;
        n = 0;
        s_ad = '0; s_oe = 0; s_rd = 1; s_wr = 1; s_ah = '0;
        @(negedge clk);
        while (!rd_n || !wr_n) begin
          ready_in = !(n < lo_len);
          if (it.t3_glitch && n == 1) ready_in = 1'b0;
          if (n == 0) chk("R2 latch strobe one cycle", ale, 1'b0);
          chk("R3 read strobe", rd_n, it.wr);
          chk("R3 write strobe", wr_n, !it.wr);
          chk("R7 data drive", ad_oe, it.wr);
          if (it.wr) chk("R7 write byte", ad_out, it.data);
          chk("R8 status", ah_out, stat_of(it.io, it.wr));
          chk("R8 io select", io_sel, it.io);
          if (n == 1) begin
            s_ad = ad_out; s_oe = ad_oe; s_rd = rd_n; s_wr = wr_n; s_ah = ah_out;
          end
          if (n >= 2) chk("R5 wait hold", {ad_out, ad_oe, rd_n, wr_n, ah_out},
                          {s_ad, s_oe, s_rd, s_wr, s_ah});
          n++;
          if (n > 64) break;
          @(negedge clk);
        end
        ready_in = 1'b1;
        chk("R4 strobe cycles (wait count)", n, exp_n);
        chk("R3 strobes off in T4", {rd_n, wr_n}, 2'b11);
        chk("R6 rsp_valid", rsp_valid, !it.wr);
        if (!it.wr) chk("R6 read data", rsp_rdata, mem_val(it.addr));
        chk("R7 T4 drive", ad_oe, it.wr);
        chk("R10 ready in T4", req_ready, 1'b1);
        t4_cyc = cyc;
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobes", {ale, rd_n, wr_n}, 3'b011);
    chk("R1 drives", {ad_oe, ah_oe}, 2'b00);
    chk("R1 req_ready", req_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {ale, ad_oe, ah_oe, req_ready}, 4'b0001);

    issue(1'b1, 1'b0, 20'h12345, 8'h3C, 0, 1'b0); release_req();
    wait (done_cnt == 1); @(negedge clk);
    idle_check(1'b1, 8'h3C, stat_of(1'b0, 1'b1));

    issue(1'b0, 1'b0, 20'hABCDE, 8'h00, 0, 1'b0); release_req();
    wait (done_cnt == 2); @(negedge clk);
    idle_check(1'b0, 8'h00, stat_of(1'b0, 1'b0));

    issue(1'b0, 1'b1, 20'h00F0F, 8'h00, 3, 1'b0); release_req();
    wait (done_cnt == 3); @(negedge clk);
    idle_check(1'b0, 8'h00, stat_of(1'b1, 1'b0));

    issue(1'b1, 1'b1, 20'h55AA1, 8'hE7, 1, 1'b0); release_req();
    wait (done_cnt == 4); @(negedge clk);
    idle_check(1'b1, 8'hE7, stat_of(1'b1, 1'b1));

    // R4: ready low during T3 only must not add a wait phase
    issue(1'b0, 1'b0, 20'h0C0DE, 8'h00, 0, 1'b1); release_req();
    wait (done_cnt == 5); @(negedge clk);

    // R10: back-to-back transfers
    issue(1'b1, 1'b0, 20'h22222, 8'h81, 2, 1'b0);
    issue(1'b0, 1'b0, 20'h33333, 8'h00, 0, 1'b0); release_req();
    wait (done_cnt == 7);
    chk("R10 no idle between cycles", last_gap, 1);
    @(negedge clk);
    idle_check(1'b0, 8'h00, stat_of(1'b0, 1'b0));

    issue(1'b0, 1'b1, 20'hFEDCB, 8'h00, 5, 1'b0); release_req();
    wait (done_cnt == 8); @(negedge clk);
    idle_check(1'b0, 8'h00, stat_of(1'b1, 1'b0));

    chk("R2 no stray cycles", q.size(), 0);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule